// File: doc/BRIEF.md
# Keyed One-Shot Configuration Write Guard

This block is a small register file that shields two configuration registers, the flash interface setup and the flash timing word, from stray writes. Software first writes a 16-bit unlock key to a lock register. That opens a window that is good for one write only. The next write to either shielded register is accepted and shuts the window again. A shielded write made while the window is shut is dropped, and a sticky fault bit records it.

Two unshielded registers sit beside the shielded ones: a scratch word and the fault register. Writes to them never touch the window. The bus is a plain single-cycle register port. Writes take effect at the rising clock edge. Reads are combinational from the address.

Top module: `cfg_key_guard`

## Requirements
- R1: After reset the window is shut (lock register reads 0), the interface register reads 0, the timing register reads 0x07FF_FFFF, the scratch register reads 0 and the fault register reads 0.
- R2: A write to address 0 whose low 16 data bits equal 0xA25E opens the window, whatever the upper 16 bits hold. While the window is open, reading address 0 returns 1 in bit 0.
- R3: A write to address 0 whose low 16 bits differ from 0xA25E shuts any open window.
- R4: While the window is open, one write to address 1 (interface) or address 2 (timing, 27 bits wide, upper bits read 0) is stored and shuts the window. A second shielded write needs a fresh key.
- R5: A write to address 1 or 2 while the window is shut leaves that register unchanged and sets bit 0 of address 4 (fault).
- R6: The fault bit stays set until address 4 is written with data bit 0 equal to 1. Writing address 4 with bit 0 equal to 0 leaves the bit unchanged.
- R7: Writes to address 3 (scratch, 32 bits) and to address 4 neither open, shut nor use up the window. Scratch writes are always stored.
- R8: The interface register holds 4 bits: bit 3 write-protect enable, bit 2 large-block mode, bit 1 five-byte address mode, bit 0 16-bit bus mode. Data bits above bit 3 are dropped and read back as 0.
- R9: Addresses 5 to 15 read 0, and writes to them change no state, including the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The hardest situation to reach is an open window that survives a stream of unrelated traffic and is then used up by exactly one shielded write. Random stimulus rarely produces a correct key followed only by scratch, fault and unmapped writes. The bench therefore builds this case on purpose, then checks the lock readback, the stored value and the relock. The random phase sends about half of its lock writes with the real key, some of them with junk in the upper bits. This keeps open-window states frequent, so the random checks against the bench model cover them.

// File: rtl/cfg_key_pkg.sv
package cfg_key_pkg;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 32;
    localparam int KEY_W    = 16;
    localparam int IFCFG_W  = 4;
    localparam int TIMING_W = 27;

    localparam logic [KEY_W-1:0]  UNLOCK_KEY = 16'hA25E;

    localparam logic [ADDR_W-1:0] A_LOCK    = 4'd0;
    localparam logic [ADDR_W-1:0] A_IFCFG   = 4'd1;
    localparam logic [ADDR_W-1:0] A_TIMING  = 4'd2;
    localparam logic [ADDR_W-1:0] A_SCRATCH = 4'd3;
    localparam logic [ADDR_W-1:0] A_FAULT   = 4'd4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LOCK,
        SEL_IFCFG,
        SEL_TIMING,
        SEL_SCRATCH,
        SEL_FAULT
    } reg_sel_e;

    typedef struct packed {
        logic                open;
        logic [IFCFG_W-1:0]  ifcfg;
        logic [TIMING_W-1:0] timing;
        logic [DATA_W-1:0]   scratch;
        logic                fault;
    } guard_state_t;
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
    import cfg_key_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        unique case (addr)
            A_LOCK:    sel = SEL_LOCK;
            A_IFCFG:   sel = SEL_IFCFG;
            A_TIMING:  sel = SEL_TIMING;
            A_SCRATCH: sel = SEL_SCRATCH;
            A_FAULT:   sel = SEL_FAULT;
            default:   sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/cfg_key_match.sv
module cfg_key_match #(
    parameter int              KEY_W = 16,
    parameter logic [KEY_W-1:0] KEY  = '0
) (
    input  logic [KEY_W-1:0] key_in,
    output logic             hit
);
    // Full-width compare: every key bit must match
    always_comb begin
        hit = (key_in == KEY);
    end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import cfg_key_pkg::*;
(
    input  reg_sel_e          sel,
    input  guard_state_t      st,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        unique case (sel)
            SEL_LOCK:    rdata = DATA_W'(st.open);
            SEL_IFCFG:   rdata = DATA_W'(st.ifcfg);
            SEL_TIMING:  rdata = DATA_W'(st.timing);
            SEL_SCRATCH: rdata = st.scratch;
            SEL_FAULT:   rdata = DATA_W'(st.fault);
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfg_key_guard.sv
module cfg_key_guard
    import cfg_key_pkg::*;
#(
    parameter logic [IFCFG_W-1:0]  IFCFG_RST  = '0,
    parameter logic [TIMING_W-1:0] TIMING_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam guard_state_t RST_STATE = '{
        open:    1'b0,
        ifcfg:   IFCFG_RST,
        timing:  TIMING_RST,
        scratch: '0,
        fault:   1'b0
    };

    guard_state_t st_d, st_q;
    reg_sel_e     sel;
    logic         key_hit;

    cfg_addr_decode u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    cfg_key_match #(
        .KEY_W (KEY_W),
        .KEY   (UNLOCK_KEY)
    ) u_key (
        .key_in (bus_wdata[KEY_W-1:0]),
        .hit    (key_hit)
    );

    cfg_read_mux u_rd (
        .sel   (sel),
        .st    (st_q),
        .rdata (bus_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (bus_we) begin
            unique case (sel)
                SEL_LOCK: st_d.open = key_hit;
                SEL_IFCFG: begin
                    if (st_q.open) begin
                        st_d.ifcfg = bus_wdata[IFCFG_W-1:0];
                        st_d.open  = 1'b0;
                    end else begin
                        st_d.fault = 1'b1;
                    end
                end
                SEL_TIMING: begin
                    if (st_q.open) begin
                        st_d.timing = bus_wdata[TIMING_W-1:0];
                        st_d.open   = 1'b0;
                    end else begin
                        st_d.fault = 1'b1;
                    end
                end
                SEL_SCRATCH: st_d.scratch = bus_wdata;
                SEL_FAULT: begin
                    if (bus_wdata[0]) st_d.fault = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cfg_key_guard_chk.sv
module cfg_key_guard_chk
    import cfg_key_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic                open_q,
    input logic [IFCFG_W-1:0]  ifcfg_q,
    input logic [TIMING_W-1:0] timing_q,
    input logic                fault_q
);
    logic wr_lock, wr_prot, wr_side;
    assign wr_lock = bus_we && (bus_addr == A_LOCK);
    assign wr_prot = bus_we && ((bus_addr == A_IFCFG) || (bus_addr == A_TIMING));
    assign wr_side = bus_we && (bus_addr != A_LOCK) && (bus_addr != A_IFCFG)
                     && (bus_addr != A_TIMING);

    p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && bus_wdata[KEY_W-1:0] == UNLOCK_KEY) |=> open_q);

    p_bad_key_shuts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && bus_wdata[KEY_W-1:0] != UNLOCK_KEY) |=> !open_q);

    p_one_shot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_prot && open_q) |=> !open_q);

    p_locked_ifcfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_IFCFG && !open_q) |=> ($stable(ifcfg_q) && fault_q));

    p_locked_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_TIMING && !open_q) |=> ($stable(timing_q) && fault_q));

    p_fault_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !(bus_we && bus_addr == A_FAULT && bus_wdata[0])) |=> fault_q);

    p_side_keeps_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_side |=> $stable(open_q));
endmodule

bind cfg_key_guard cfg_key_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .open_q    (st_q.open),
    .ifcfg_q   (st_q.ifcfg),
    .timing_q  (st_q.timing),
    .fault_q   (st_q.fault)
);

// File: tb/cfg_key_guard_tb.sv
module cfg_key_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // bench model of the register file
    bit          m_open;
    logic [3:0]  m_ifcfg;
    logic [26:0] m_timing;
    logic [31:0] m_scratch;
    bit          m_fault;

    always #5 clk = ~clk;

    cfg_key_guard u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        case (a)
            4'd0:    return {31'd0, m_open};
            4'd1:    return {28'd0, m_ifcfg};
            4'd2:    return {5'd0, m_timing};
            4'd3:    return m_scratch;
            4'd4:    return {31'd0, m_fault};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] a);
        case (a)
            4'd0:    return "R2";
            4'd1:    return "R8";
            4'd2:    return "R4";
            4'd3:    return "R7";
            4'd4:    return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic model_write(input logic [3:0] a, input logic [31:0] d);
        case (a)
            4'd0: m_open = (d[15:0] == 16'hA25E);
            4'd1: if (m_open) begin m_ifcfg = d[3:0]; m_open = 1'b0; end
                  else m_fault = 1'b1;
            4'd2: if (m_open) begin m_timing = d[26:0]; m_open = 1'b0; end
                  else m_fault = 1'b1;
            4'd3: m_scratch = d;
            4'd4: if (d[0]) m_fault = 1'b0;
            default: ;
        endcase
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        model_write(a, d);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp_read(a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        m_open = 0; m_ifcfg = '0; m_timing = '1; m_scratch = '0; m_fault = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values at every mapped address, R9 unmapped reads zero
        rd_chk("R1", 4'd0);
        rd_chk("R1", 4'd1);
        chk("R1", bus_rdata, 32'h0000_0000);
        rd_chk("R1", 4'd2);
        chk("R1", bus_rdata, 32'h07FF_FFFF);
        rd_chk("R1", 4'd3);
        rd_chk("R1", 4'd4);
        rd_chk("R9", 4'd9);

        // R5: shielded write without key is dropped and flagged
        wr(4'd1, 32'hF);
        rd_chk("R5", 4'd1);
        chk("R5", bus_rdata, 32'h0);
        rd_chk("R5", 4'd4);
        chk("R5", bus_rdata, 32'h1);

        // R6: clearing needs bit0 = 1
        wr(4'd4, 32'hFFFF_FFFE);
        rd_chk("R6", 4'd4);
        chk("R6", bus_rdata, 32'h1);
        wr(4'd4, 32'h1);
        rd_chk("R6", 4'd4);
        chk("R6", bus_rdata, 32'h0);

        // R2: key with junk in upper half still opens
        wr(4'd0, 32'hFFFF_A25E);
        rd_chk("R2", 4'd0);
        chk("R2", bus_rdata, 32'h1);

        // R7 / R9: side writes keep the window open
        wr(4'd3, 32'hDEAD_BEEF);
        wr(4'd4, 32'h1);
        wr(4'd9, 32'h1234_5678);
        rd_chk("R7", 4'd0);
        chk("R7", bus_rdata, 32'h1);
        rd_chk("R7", 4'd3);
        rd_chk("R9", 4'd9);

        // R4 / R8: one shielded write accepted, upper bits dropped, relock
        wr(4'd1, 32'hFFFF_FFF5);
        rd_chk("R8", 4'd1);
        chk("R8", bus_rdata, 32'h5);
        rd_chk("R4", 4'd0);
        chk("R4", bus_rdata, 32'h0);
        wr(4'd2, 32'h0000_0123);
        rd_chk("R4", 4'd2);
        chk("R4", bus_rdata, 32'h07FF_FFFF);
        rd_chk("R5", 4'd4);
        chk("R5", bus_rdata, 32'h1);
        wr(4'd4, 32'h1);

        // R3: wrong key cancels a pending unlock
        wr(4'd0, 32'h0000_A25E);
        wr(4'd0, 32'h0000_A25F);
        rd_chk("R3", 4'd0);
        chk("R3", bus_rdata, 32'h0);
        wr(4'd2, 32'h0000_0777);
        rd_chk("R3", 4'd2);

        // R4: timing register stores 27 bits after a fresh key
        wr(4'd0, 32'h0000_A25E);
        wr(4'd2, 32'hFFFF_FFFF & 32'hF123_4567);
        rd_chk("R4", 4'd2);
        chk("R4", bus_rdata, 32'h0123_4567);

        // random phase
        for (int i = 0; i < 600; i++) begin
            logic [3:0]  a;
            logic [31:0] d;
            a = 4'($urandom_range(0, 6));
            d = $urandom;
            if (a == 4'd0 && $urandom_range(0, 1) == 1)
                d = {d[31:16], 16'hA25E};
            wr(a, d);
            a = 4'($urandom_range(0, 6));
            rd_chk(req_of(a), a);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule